// File: doc/BRIEF.md
# Balanced Spatial Partition Builder

This engine takes a list of fixed-point 3-D points held in an on-chip buffer and reorders it into a balanced, axis-aligned binary partition tree. The tree is kept as an implicit heap in a node memory. Each node records the index of its first point, the index of its last point and the coordinate at which it is split. The engine works one tree level at a time. For each node on a level it averages the node's points along that level's axis to get the split value. It then copies the node's points into the other point buffer: first the points below the split, then the points at or above it. The two point buffers swap roles after every level, and every write to a point buffer goes to the next sequential address.

Software fills buffer 0 through a load port while the engine is idle. It then pulses `start` with a point count and a level count, and waits for `done`. After that, the finished point order can be read from the buffer named by `res_buf`, and the tree can be read from the node read port.

Top module: `kdb_builder`

## Requirements
- R1: On start, the root (node 0) is given first index 0, last index count−1 (modulo 2^32) and split 0. A point count above N_MAX is treated as N_MAX, and a level count above L_MAX is treated as L_MAX.
- R2: The children of node i are stored at index 2i+1 (left) and 2i+2 (right). The left child's range starts where the write index stood when the parent began. It ends one before the write index at the end of the below-split sweep. The right child starts at that point and ends one before the write index at the end of the at-or-above sweep.
- R3: The split axis of level j is j mod 3, where 0 selects x, 1 selects y and 2 selects z.
- R4: The split of a non-empty node is floor(sum of its points' coordinates on the level axis / number of points), stored zero-extended in 32 bits.
- R5: Within each node, the points with coordinate < split are written first and those with coordinate ≥ split follow. Each group keeps the relative order the points had in the source buffer.
- R6: Each level writes exactly count points into the destination buffer, starting at address 0. Buffers alternate, with level 0 reading buffer 0, and `res_buf` equals the level count mod 2 after completion.
- R7: A node whose range is empty (last = first−1) keeps split 0. Both of its children receive empty ranges that begin at the current write index.
- R8: `done` is high for exactly one cycle after the final level has been written.
- R9: With a level count of 0, `done` follows start after one cycle, only the root is written and `res_buf` is 0.
- R10: Load writes go into buffer 0 only while idle. The point read port returns the contents of the buffer selected by `res_buf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a build (sampled while idle) |
| num_points | input | CNTW | Number of points to partition |
| num_levels | input | LW | Number of levels to build |
| ld_we | input | 1 | Load write enable into buffer 0 |
| ld_addr | input | AW | Load address |
| ld_x | input | 16 | Load x coordinate |
| ld_y | input | 16 | Load y coordinate |
| ld_z | input | 16 | Load z coordinate |
| rd_addr | input | AW | Result point read address |
| rd_x | output | 16 | Result point x |
| rd_y | output | 16 | Result point y |
| rd_z | output | 16 | Result point z |
| nd_addr | input | NAW | Node read address |
| nd_first | output | 32 | Node first point index |
| nd_last | output | 32 | Node last point index |
| nd_split | output | 32 | Node split coordinate |
| done | output | 1 | One-cycle completion pulse |
| res_buf | output | 1 | Buffer holding the final order |

## Verification
Several properties are checked on every cycle. The divider's quotient must bracket the accumulated sum against the node count. Every sequential point write must stay below the point count, and each finished level must have written exactly that count. `done` must never last longer than one cycle, and `res_buf` may change only together with it. The bench's scenarios are needed for the rest. They show that splits use the axis of the right level, that the below/above grouping is stable, that the child ranges of every heap node are correct (including empty subtrees built from identical points), and that the load and read ports reach the correct buffer.

// File: rtl/kdb_pkg.sv
package kdb_pkg;

    localparam int COORD_W = 16;
    localparam int IDX_W   = 32;

    typedef logic [COORD_W-1:0] coord_t;

    typedef struct packed {
        coord_t x;
        coord_t y;
        coord_t z;
    } point_t;

    typedef struct packed {
        logic [IDX_W-1:0] first;
        logic [IDX_W-1:0] last;
        logic [IDX_W-1:0] split;
    } node_t;

    typedef enum logic [1:0] {
        AX_X = 2'd0,
        AX_Y = 2'd1,
        AX_Z = 2'd2
    } axis_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_NODE,
        S_SUM,
        S_DIVGO,
        S_DIVWAIT,
        S_LEFT,
        S_RIGHT,
        S_CHL,
        S_CHR,
        S_NEXT
    } state_t;

    function automatic coord_t axis_coord(point_t p, axis_t a);
        case (a)
            AX_X:    return p.x;
            AX_Y:    return p.y;
            default: return p.z;
        endcase
    endfunction

    function automatic axis_t axis_next(axis_t a);
        case (a)
            AX_X:    return AX_Y;
            AX_Y:    return AX_Z;
            default: return AX_X;
        endcase
    endfunction

endpackage

// File: rtl/kdb_ram.sv
module kdb_ram #(
    parameter type T     = logic [7:0],
    parameter int  DEPTH = 16,
    parameter int  AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  T              wdata,
    input  logic [AW-1:0] raddr_a,
    output T              rdata_a,
    input  logic [AW-1:0] raddr_b,
    output T              rdata_b
);

    T mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/kdb_div.sv
module kdb_div #(
    parameter int NW = 21,
    parameter int DW = 5,
    localparam int KW = $clog2(NW + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          done,
    output logic [NW-1:0] quo
);

    logic [DW-1:0] rem;
    logic [DW-1:0] dsr;
    logic [KW-1:0] steps;
    logic          run;
    logic [DW:0]   trial;

    assign trial = {rem, quo[NW-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            done  <= 1'b0;
            rem   <= '0;
            dsr   <= '0;
            quo   <= '0;
            steps <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                quo   <= num;
                rem   <= '0;
                dsr   <= den;
                steps <= KW'(NW);
                run   <= 1'b1;
            end else if (run) begin
                if (trial >= {1'b0, dsr}) begin
                    rem <= DW'(trial - {1'b0, dsr});
                    quo <= {quo[NW-2:0], 1'b1};
                end else begin
                    rem <= trial[DW-1:0];
                    quo <= {quo[NW-2:0], 1'b0};
                end
                steps <= steps - KW'(1);
                if (steps == KW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/kdb_builder.sv
module kdb_builder
    import kdb_pkg::*;
#(
    parameter int  N_MAX  = 16,
    parameter int  L_MAX  = 3,
    localparam int AW     = (N_MAX > 1) ? $clog2(N_MAX) : 1,
    localparam int CNTW   = $clog2(N_MAX + 1),
    localparam int LW     = (L_MAX > 0) ? $clog2(L_MAX + 1) : 1,
    localparam int NODES  = (1 << (L_MAX + 1)) - 1,
    localparam int NAW    = $clog2(NODES + 1),
    localparam int NDEPTH = 1 << NAW,
    localparam int SW     = COORD_W + CNTW
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [CNTW-1:0]    num_points,
    input  logic [LW-1:0]      num_levels,
    input  logic               ld_we,
    input  logic [AW-1:0]      ld_addr,
    input  logic [COORD_W-1:0] ld_x,
    input  logic [COORD_W-1:0] ld_y,
    input  logic [COORD_W-1:0] ld_z,
    input  logic [AW-1:0]      rd_addr,
    output logic [COORD_W-1:0] rd_x,
    output logic [COORD_W-1:0] rd_y,
    output logic [COORD_W-1:0] rd_z,
    input  logic [NAW-1:0]     nd_addr,
    output logic [IDX_W-1:0]   nd_first,
    output logic [IDX_W-1:0]   nd_last,
    output logic [IDX_W-1:0]   nd_split,
    output logic               done,
    output logic               res_buf
);

    state_t             st;
    logic               sel;
    logic [LW-1:0]      lvl;
    logic [LW-1:0]      lv_reg;
    axis_t              ax;
    logic [NAW-1:0]     idx;
    logic [NAW-1:0]     lvl_end;
    logic [IDX_W-1:0]   ptr;
    logic [IDX_W-1:0]   wr;
    logic [IDX_W-1:0]   wr_base;
    logic [IDX_W-1:0]   wr_mid;
    logic [IDX_W-1:0]   cur_first;
    logic [IDX_W-1:0]   cur_last;
    logic [IDX_W-1:0]   cur_cnt;
    logic [SW-1:0]      acc;
    coord_t             split;
    logic [CNTW-1:0]    n_reg;

    logic [CNTW-1:0]    n_eff;
    logic [LW-1:0]      l_eff;

    point_t             buf_rd_a [2];
    point_t             buf_rd_b [2];
    point_t             src_pt;
    coord_t             src_c;
    point_t             ld_pt;
    logic               eng_we;

    node_t              node_a;
    node_t              node_b;
    node_t              nm_wd;
    logic               nm_we;
    logic [NAW-1:0]     nm_wa;
    logic [NAW-1:0]     child_l;
    logic [NAW-1:0]     child_r;
    logic [IDX_W-1:0]   node_cnt;
    logic               lvl_fin;

    logic               div_go;
    logic               div_done;
    logic [SW-1:0]      div_quo;
    logic [CNTW-1:0]    div_den;

    // Input limits
    assign n_eff = (num_points > CNTW'(N_MAX)) ? CNTW'(N_MAX) : num_points;
    assign l_eff = (num_levels > LW'(L_MAX))   ? LW'(L_MAX)   : num_levels;

    // Source point and sweep decision
    assign ld_pt  = '{x: ld_x, y: ld_y, z: ld_z};
    assign src_pt = sel ? buf_rd_a[1] : buf_rd_a[0];
    assign src_c  = axis_coord(src_pt, ax);
    assign eng_we = ((st == S_LEFT)  && (src_c <  split)) ||
                    ((st == S_RIGHT) && (src_c >= split));

    // Ping-pong point buffers
    for (genvar g = 0; g < 2; g++) begin : g_buf
        localparam logic BUF_ID = 1'(g);
        logic          eng_here;
        logic          ld_here;
        logic          we_g;
        logic [AW-1:0] wa_g;
        point_t        wd_g;

        assign eng_here = eng_we && (sel != BUF_ID);
        assign ld_here  = (BUF_ID == 1'b0) && (st == S_IDLE) && ld_we;
        assign we_g     = eng_here || ld_here;
        assign wa_g     = eng_here ? wr[AW-1:0] : ld_addr;
        assign wd_g     = eng_here ? src_pt : ld_pt;

        kdb_ram #(
            .T     (point_t),
            .DEPTH (N_MAX),
            .AW    (AW)
        ) u_pts (
            .clk     (clk),
            .we      (we_g),
            .waddr   (wa_g),
            .wdata   (wd_g),
            .raddr_a (ptr[AW-1:0]),
            .rdata_a (buf_rd_a[g]),
            .raddr_b (rd_addr),
            .rdata_b (buf_rd_b[g])
        );
    end

    assign rd_x = res_buf ? buf_rd_b[1].x : buf_rd_b[0].x;
    assign rd_y = res_buf ? buf_rd_b[1].y : buf_rd_b[0].y;
    assign rd_z = res_buf ? buf_rd_b[1].z : buf_rd_b[0].z;

    // Node heap
    assign child_l  = (idx << 1) + NAW'(1);
    assign child_r  = (idx << 1) + NAW'(2);
    assign node_cnt = node_a.last - node_a.first + IDX_W'(1);
    assign cur_cnt  = cur_last - cur_first + IDX_W'(1);
    assign lvl_fin  = (st == S_NEXT) && (idx == lvl_end);

    always_comb begin
        nm_we = 1'b0;
        nm_wa = idx;
        nm_wd = node_a;
        case (st)
            S_IDLE: begin
                if (start) begin
                    nm_we = 1'b1;
                    nm_wa = '0;
                    nm_wd = '{first: '0, last: IDX_W'(n_eff) - IDX_W'(1), split: '0};
                end
            end
            S_DIVWAIT: begin
                if (div_done) begin
                    nm_we = 1'b1;
                    nm_wd = '{first: node_a.first, last: node_a.last,
                              split: IDX_W'(div_quo[COORD_W-1:0])};
                end
            end
            S_CHL: begin
                nm_we = 1'b1;
                nm_wa = child_l;
                nm_wd = '{first: wr_base, last: wr_mid - IDX_W'(1), split: '0};
            end
            S_CHR: begin
                nm_we = 1'b1;
                nm_wa = child_r;
                nm_wd = '{first: wr_mid, last: wr - IDX_W'(1), split: '0};
            end
            default: ;
        endcase
    end

    kdb_ram #(
        .T     (node_t),
        .DEPTH (NDEPTH),
        .AW    (NAW)
    ) u_nodes (
        .clk     (clk),
        .we      (nm_we),
        .waddr   (nm_wa),
        .wdata   (nm_wd),
        .raddr_a (idx),
        .rdata_a (node_a),
        .raddr_b (nd_addr),
        .rdata_b (node_b)
    );

    assign nd_first = node_b.first;
    assign nd_last  = node_b.last;
    assign nd_split = node_b.split;

    // Mean divider
    assign div_go  = (st == S_DIVGO);
    assign div_den = cur_cnt[CNTW-1:0];

    kdb_div #(
        .NW (SW),
        .DW (CNTW)
    ) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (div_go),
        .num  (acc),
        .den  (div_den),
        .done (div_done),
        .quo  (div_quo)
    );

    // Level and node sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            sel       <= 1'b0;
            lvl       <= '0;
            lv_reg    <= '0;
            ax        <= AX_X;
            idx       <= '0;
            lvl_end   <= '0;
            ptr       <= '0;
            wr        <= '0;
            wr_base   <= '0;
            wr_mid    <= '0;
            cur_first <= '0;
            cur_last  <= '0;
            acc       <= '0;
            split     <= '0;
            n_reg     <= '0;
            done      <= 1'b0;
            res_buf   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start) begin
                        n_reg   <= n_eff;
                        lv_reg  <= l_eff;
                        sel     <= 1'b0;
                        lvl     <= '0;
                        ax      <= AX_X;
                        idx     <= '0;
                        lvl_end <= '0;
                        wr      <= '0;
                        if (l_eff == '0) begin
                            done    <= 1'b1;
                            res_buf <= 1'b0;
                        end else begin
                            st <= S_NODE;
                        end
                    end
                end
                S_NODE: begin
                    cur_first <= node_a.first;
                    cur_last  <= node_a.last;
                    wr_base   <= wr;
                    if (node_cnt == '0) begin
                        wr_mid <= wr;
                        st     <= S_CHL;
                    end else begin
                        ptr <= node_a.first;
                        acc <= '0;
                        st  <= S_SUM;
                    end
                end
                S_SUM: begin
                    acc <= acc + SW'(src_c);
                    if (ptr == cur_last) begin
                        st <= S_DIVGO;
                    end else begin
                        ptr <= ptr + IDX_W'(1);
                    end
                end
                S_DIVGO: begin
                    st <= S_DIVWAIT;
                end
                S_DIVWAIT: begin
                    if (div_done) begin
                        split <= div_quo[COORD_W-1:0];
                        ptr   <= cur_first;
                        st    <= S_LEFT;
                    end
                end
                S_LEFT: begin
                    wr <= wr + IDX_W'(eng_we);
                    if (ptr == cur_last) begin
                        ptr    <= cur_first;
                        wr_mid <= wr + IDX_W'(eng_we);
                        st     <= S_RIGHT;
                    end else begin
                        ptr <= ptr + IDX_W'(1);
                    end
                end
                S_RIGHT: begin
                    wr <= wr + IDX_W'(eng_we);
                    if (ptr == cur_last) begin
                        st <= S_CHL;
                    end else begin
                        ptr <= ptr + IDX_W'(1);
                    end
                end
                S_CHL: begin
                    st <= S_CHR;
                end
                S_CHR: begin
                    st <= S_NEXT;
                end
                S_NEXT: begin
                    if (lvl_fin) begin
                        sel <= ~sel;
                        if (lvl + LW'(1) == lv_reg) begin
                            done    <= 1'b1;
                            res_buf <= ~sel;
                            st      <= S_IDLE;
                        end else begin
                            lvl     <= lvl + LW'(1);
                            ax      <= axis_next(ax);
                            wr      <= '0;
                            idx     <= idx + NAW'(1);
                            lvl_end <= (lvl_end << 1) + NAW'(2);
                            st      <= S_NODE;
                        end
                    end else begin
                        idx <= idx + NAW'(1);
                        st  <= S_NODE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    logic unused_bits;
    assign unused_bits = ^{node_a.split, div_quo[SW-1:COORD_W],
                           ptr[IDX_W-1:AW], wr[IDX_W-1:AW],
                           cur_cnt[IDX_W-1:CNTW]};

endmodule

// File: rtl/kdb_builder_chk.sv
module kdb_builder_chk #(
    parameter int  N_MAX = 16,
    parameter int  L_MAX = 3,
    localparam int CNTW  = $clog2(N_MAX + 1),
    localparam int SW    = 16 + CNTW
) (
    input logic            clk,
    input logic            rst,
    input logic            done,
    input logic            res_buf,
    input logic            eng_we,
    input logic [31:0]     wr,
    input logic [CNTW-1:0] n_reg,
    input logic            lvl_fin,
    input logic            div_go,
    input logic            div_done,
    input logic [SW-1:0]   acc,
    input logic [CNTW-1:0] div_den,
    input logic [SW-1:0]   div_quo
);

    logic [SW-1:0]      cap_num;
    logic [CNTW-1:0]    cap_den;
    logic [SW+CNTW:0]   lo_prod;
    logic [SW+CNTW:0]   hi_prod;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_num <= '0;
            cap_den <= '0;
        end else if (div_go) begin
            cap_num <= acc;
            cap_den <= div_den;
        end
    end

    assign lo_prod = (SW+CNTW+1)'(div_quo) * (SW+CNTW+1)'(cap_den);
    assign hi_prod = lo_prod + (SW+CNTW+1)'(cap_den);

    p_mean_bracket_r4: assert property (@(posedge clk) disable iff (rst)
        div_done |-> (lo_prod <= (SW+CNTW+1)'(cap_num)) && ((SW+CNTW+1)'(cap_num) < hi_prod));

    p_write_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        eng_we |-> (wr < 32'(n_reg)));

    p_level_complete_r6: assert property (@(posedge clk) disable iff (rst)
        lvl_fin |-> (wr == 32'(n_reg)));

    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_resbuf_with_done_r6: assert property (@(posedge clk) disable iff (rst)
        !$stable(res_buf) |-> done);

endmodule

bind kdb_builder kdb_builder_chk #(
    .N_MAX (N_MAX),
    .L_MAX (L_MAX)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (done),
    .res_buf  (res_buf),
    .eng_we   (eng_we),
    .wr       (wr),
    .n_reg    (n_reg),
    .lvl_fin  (lvl_fin),
    .div_go   (div_go),
    .div_done (div_done),
    .acc      (acc),
    .div_den  (div_den),
    .div_quo  (div_quo)
);

// File: tb/kdb_builder_test.sv
module kdb_builder_test;

    localparam int N_MAX = 16;
    localparam int L_MAX = 3;
    localparam int CNTW  = 5;
    localparam int LW    = 2;
    localparam int AW    = 4;
    localparam int NAW   = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [CNTW-1:0] num_points = '0;
    logic [LW-1:0]   num_levels = '0;
    logic            ld_we = 1'b0;
    logic [AW-1:0]   ld_addr = '0;
    logic [15:0]     ld_x = '0;
    logic [15:0]     ld_y = '0;
    logic [15:0]     ld_z = '0;
    logic [AW-1:0]   rd_addr = '0;
    logic [15:0]     rd_x;
    logic [15:0]     rd_y;
    logic [15:0]     rd_z;
    logic [NAW-1:0]  nd_addr = '0;
    logic [31:0]     nd_first;
    logic [31:0]     nd_last;
    logic [31:0]     nd_split;
    logic            done;
    logic            res_buf;

    always #4 clk = ~clk;

    kdb_builder #(.N_MAX(N_MAX), .L_MAX(L_MAX)) uut (
        .clk(clk), .rst(rst), .start(start),
        .num_points(num_points), .num_levels(num_levels),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_x(ld_x), .ld_y(ld_y), .ld_z(ld_z),
        .rd_addr(rd_addr), .rd_x(rd_x), .rd_y(rd_y), .rd_z(rd_z),
        .nd_addr(nd_addr), .nd_first(nd_first), .nd_last(nd_last), .nd_split(nd_split),
        .done(done), .res_buf(res_buf)
    );

    int n_tests = 0;
    int n_fail  = 0;

    int          mx [2][16];
    int          my [2][16];
    int          mz [2][16];
    logic [31:0] mf [16];
    logic [31:0] ml [16];
    logic [31:0] ms [16];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int coord(input int b, input int i, input int a);
        if (a == 0) return mx[b][i];
        if (a == 1) return my[b][i];
        return mz[b][i];
    endfunction

    // Reference tree from the requirements (R1..R7)
    task automatic model(input int n, input int L);
        for (int i = 0; i < 16; i++) begin
            mf[i] = '0; ml[i] = '0; ms[i] = '0;
        end
        mf[0] = '0;
        ml[0] = 32'(n - 1);
        for (int l = 0; l < L; l++) begin
            int s  = l % 2;
            int d  = 1 - s;
            int w  = 0;
            int ax = l % 3;
            for (int i = (1 << l) - 1; i <= (1 << (l + 1)) - 2; i++) begin
                logic [31:0] cnt = ml[i] - mf[i] + 32'd1;
                int base = w;
                int mid  = w;
                if (cnt != 0) begin
                    longint sum = 0;
                    int sp;
                    for (int p = int'(mf[i]); p <= int'(ml[i]); p++) sum += coord(s, p, ax);
                    sp = int'(sum / longint'(cnt));
                    ms[i] = 32'(sp);
                    for (int p = int'(mf[i]); p <= int'(ml[i]); p++) begin
                        if (coord(s, p, ax) < sp) begin
                            mx[d][w] = mx[s][p]; my[d][w] = my[s][p]; mz[d][w] = mz[s][p];
                            w++;
                        end
                    end
                    mid = w;
                    for (int p = int'(mf[i]); p <= int'(ml[i]); p++) begin
                        if (coord(s, p, ax) >= sp) begin
                            mx[d][w] = mx[s][p]; my[d][w] = my[s][p]; mz[d][w] = mz[s][p];
                            w++;
                        end
                    end
                end
                mf[2*i+1] = 32'(base);
                ml[2*i+1] = 32'(mid - 1);
                ms[2*i+1] = '0;
                mf[2*i+2] = 32'(mid);
                ml[2*i+2] = 32'(w - 1);
                ms[2*i+2] = '0;
            end
        end
    endtask

    task automatic load(input int n, input int pat);
        for (int i = 0; i < n; i++) begin
            int x, y, z;
            case (pat)
                0: begin x = (i*97 + 13) % 4096; y = (i*211 + 7) % 1000; z = (i*53) % 300; end
                1: begin x = 500; y = 500; z = 500; end
                2: begin x = 65535 - i; y = 65535 - 3*i; z = 65000 + i*29; end
                default: begin x = (i*7919) % 65536; y = (i*i*31) % 5000; z = (16 - i)*100; end
            endcase
            mx[0][i] = x; my[0][i] = y; mz[0][i] = z;
            @(negedge clk);
            ld_we = 1'b1; ld_addr = AW'(i);
            ld_x = 16'(x); ld_y = 16'(y); ld_z = 16'(z);
        end
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic run(input int n, input int L, input int pat);
        int cyc = 0;
        int fin;
        load(n, pat);
        model(n, L);
        @(negedge clk);
        num_points = CNTW'(n); num_levels = LW'(L); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 40000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            check(1'b0, "R8", "watchdog expired", cyc, 0);
            return;
        end
        check(1'b1, "R8", "done seen", 1, 1);
        if (L == 0) check(cyc == 0, "R9", "done latency", cyc, 0);
        @(negedge clk);
        check(done == 1'b0, "R8", "done width", done, 0);
        check(res_buf == 1'(L % 2), L == 0 ? "R9" : "R6", "result buffer", res_buf, L % 2);
        fin = L % 2;
        for (int i = 0; i < (1 << (L + 1)) - 1; i++) begin
            logic [31:0] cnt = ml[i] - mf[i] + 32'd1;
            string tg;
            nd_addr = NAW'(i);
            #1;
            if (i == 0) tg = (L == 0) ? "R9" : "R1";
            else if (cnt == 0) tg = "R7";
            else tg = "R2";
            check(nd_first == mf[i], tg, $sformatf("node %0d first", i), nd_first, mf[i]);
            check(nd_last  == ml[i], tg, $sformatf("node %0d last", i),  nd_last,  ml[i]);
            check(nd_split == ms[i], (cnt == 0) ? "R7" : "R3 R4",
                  $sformatf("node %0d split", i), nd_split, ms[i]);
        end
        for (int i = 0; i < n; i++) begin
            rd_addr = AW'(i);
            #1;
            check(rd_x == 16'(mx[fin][i]), "R5 R10", $sformatf("point %0d x", i), rd_x, mx[fin][i]);
            check(rd_y == 16'(my[fin][i]), "R5 R10", $sformatf("point %0d y", i), rd_y, my[fin][i]);
            check(rd_z == 16'(mz[fin][i]), "R5 R10", $sformatf("point %0d z", i), rd_z, mz[fin][i]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R8", "done after reset", done, 0);
        check(res_buf == 1'b0, "R6", "res_buf after reset", res_buf, 0);

        run(16, 3, 0);
        run(16, 3, 2);
        run(13, 2, 3);
        run(1, 3, 0);
        run(0, 2, 0);
        run(16, 0, 3);
        run(16, 3, 1);
        run(7, 1, 0);
        run(16, 3, 3);
        run(5, 3, 2);
        run(16, 2, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule